// File: doc/BRIEF.md
# Repair Key Burst Qualifier

This block sits on the device side of a memory interface while row-repair mode is active. Each time a write command is accepted, it waits out the write latency, which is the sum of the CAS write latency, additive latency and parity latency settings. It then inspects the data lines over a four-clock window, which holds eight double-rate beats. From that burst it decides whether the host sent a valid repair key.

The decision has three possible outcomes. If every line is low on every beat, the burst asks for a repair. If every line is high for at least four consecutive beats (two clocks' worth), the burst is an explicit abort and the stored data is retained. Any other pattern gives an undefined result. The data arrive as a pair per clock: one input holds the beat taken on the rising edge and the other holds the beat taken on the falling edge, which follows it. A one-cycle strobe carries the outcome code. A second write command that arrives while a window is already pending is dropped, and it sets a sticky error flag.

Top module: `repair_key_qualifier`

## Requirements
- R1: After reset, verdict_valid_o is 0, verdict_o is 2'b00 and overlap_err_o is 0.
- R2: With the command sampled at clock edge E, the beat pairs are taken at edges E+WL, E+WL+1, E+WL+2 and E+WL+3. In each pair the rising beat comes before the falling beat. Data at other edges has no effect on the outcome, and the strobe appears after edge E+WL+3.
- R3: verdict_o is 2'b01 (repair) when all lines are low on all eight beats.
- R4: verdict_o is 2'b10 (retain) when all lines are high on at least four consecutive beats. This includes a run that crosses a clock boundary.
- R5: verdict_o is 2'b11 (undefined) for every other pattern, including a single high bit and an all-high run of only three beats.
- R6: verdict_valid_o is high for exactly one cycle per accepted command, and verdict_o reads 2'b00 whenever the strobe is low.
- R7: A write command sampled while a window is pending is ignored: the pending verdict keeps its timing and code. It also sets overlap_err_o, which stays set until reset.
- R8: WL is cwl_i + al_i + pl_i, taken at the command edge, and a sum of zero counts as one. Changes to the latency inputs after the command edge do not move the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_cmd_i | input | 1 | Write command strobe while in repair mode |
| cwl_i | input | 5 | CAS write latency in clocks |
| al_i | input | 5 | Additive latency in clocks |
| pl_i | input | 3 | Parity latency in clocks |
| dq_rise_i | input | 4 | Data lines, beat on the rising edge |
| dq_fall_i | input | 4 | Data lines, beat on the falling edge |
| verdict_valid_o | output | 1 | One-cycle outcome strobe |
| verdict_o | output | 2 | 00 idle, 01 repair, 10 retain, 11 undefined |
| overlap_err_o | output | 1 | Sticky flag for an ignored overlapping command |

## Verification
The hardest cases to reach are the borders of the classification: an all-high run of exactly four beats that starts on a falling beat and so crosses a clock boundary, a run of only three, and a single high bit on the last beat. Random bursts seldom produce these, so the bench drives each of them directly at a chosen position and also mixes them into the random classes. To show that only the window counts, every cycle outside the window carries random data. In some bursts the latency inputs are scrambled after the command, and a second command is injected at the end.

// File: rtl/rkq_pkg.sv
package rkq_pkg;
  typedef enum logic [1:0] {
    RKQ_IDLE   = 2'b00,
    RKQ_REPAIR = 2'b01,
    RKQ_RETAIN = 2'b10,
    RKQ_UNDEF  = 2'b11
  } rkq_verdict_e;
endpackage

// File: rtl/rkq_window_ctrl.sv
module rkq_window_ctrl #(
  parameter int CWL_W    = 5,
  parameter int AL_W     = 5,
  parameter int PL_W     = 3,
  parameter int WIN_CLKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_cmd_i,
  input  logic [CWL_W-1:0] cwl_i,
  input  logic [AL_W-1:0]  al_i,
  input  logic [PL_W-1:0]  pl_i,
  output logic             cap_o,
  output logic             first_o,
  output logic             last_o,
  output logic             overlap_o
);
  localparam int MAX_AW = (CWL_W > AL_W) ? CWL_W : AL_W;
  localparam int MAX_W  = (MAX_AW > PL_W) ? MAX_AW : PL_W;
  localparam int WL_W   = MAX_W + 2;
  localparam int IDX_W  = (WIN_CLKS > 1) ? $clog2(WIN_CLKS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WIN_CLKS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CAP} st_e;

  st_e              state_q;
  logic [WL_W-1:0]  cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [WL_W-1:0]  wl_sum, wl_eff;

  assign wl_sum = WL_W'(cwl_i) + WL_W'(al_i) + WL_W'(pl_i);
  assign wl_eff = (wl_sum == '0) ? WL_W'(1) : wl_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (wr_cmd_i) begin
          idx_q <= '0;
          if (wl_eff == WL_W'(1)) state_q <= ST_CAP;
          else begin
            state_q <= ST_WAIT;
            cnt_q   <= wl_eff - WL_W'(1);
          end
        end
        ST_WAIT: begin
          if (cnt_q == WL_W'(1)) state_q <= ST_CAP;
          else cnt_q <= cnt_q - WL_W'(1);
        end
        ST_CAP: begin
          if (idx_q == IDX_LAST) state_q <= ST_IDLE;
          else idx_q <= idx_q + IDX_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cap_o     = (state_q == ST_CAP);
  assign first_o   = cap_o && (idx_q == '0);
  assign last_o    = cap_o && (idx_q == IDX_LAST);
  assign overlap_o = wr_cmd_i && (state_q != ST_IDLE);

  // window is contiguous once opened
  p_idx_steps_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_o && !last_o) |=> (cap_o && idx_q == $past(idx_q) + IDX_W'(1)));

  // command while busy leaves the countdown untouched
  p_wait_ignores_cmd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && cnt_q != WL_W'(1)) |=> (state_q == ST_WAIT && cnt_q == $past(cnt_q) - WL_W'(1)));
endmodule

// File: rtl/rkq_beat_scan.sv
module rkq_beat_scan
  import rkq_pkg::*;
#(
  parameter int DQ_W      = 4,
  parameter int BEATS     = 2,
  parameter int RUN_BEATS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cap_i,
  input  logic                       first_i,
  input  logic [BEATS-1:0][DQ_W-1:0] beats_i,
  output rkq_verdict_e               verdict_o
);
  localparam int RUN_W = $clog2(RUN_BEATS + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_BEATS);

  logic [BEATS-1:0] beat_zero, beat_ones;
  logic             low_q, hit_q;
  logic [RUN_W-1:0] run_q;
  logic             low_c [BEATS+1];
  logic             hit_c [BEATS+1];
  logic [RUN_W-1:0] run_c [BEATS+1];

  for (genvar g = 0; g < BEATS; g++) begin : g_beat
    assign beat_zero[g] = ~|beats_i[g];
    assign beat_ones[g] = &beats_i[g];
  end

  always_comb begin
    low_c[0] = first_i ? 1'b1 : low_q;
    hit_c[0] = first_i ? 1'b0 : hit_q;
    run_c[0] = first_i ? '0 : run_q;
    for (int b = 0; b < BEATS; b++) begin
      low_c[b+1] = low_c[b] & beat_zero[b];
      if (!beat_ones[b])          run_c[b+1] = '0;
      else if (run_c[b] == RUN_MAX) run_c[b+1] = RUN_MAX;
      else                        run_c[b+1] = run_c[b] + RUN_W'(1);
      hit_c[b+1] = hit_c[b] | (run_c[b+1] == RUN_MAX);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= 1'b1;
      hit_q <= 1'b0;
      run_q <= '0;
    end else if (cap_i) begin
      low_q <= low_c[BEATS];
      hit_q <= hit_c[BEATS];
      run_q <= run_c[BEATS];
    end
  end

  always_comb begin
    if (low_c[BEATS])      verdict_o = RKQ_REPAIR;
    else if (hit_c[BEATS]) verdict_o = RKQ_RETAIN;
    else                   verdict_o = RKQ_UNDEF;
  end

  // a high beat rules out repair for the rest of the window
  p_low_drops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !first_i && !low_q) |-> (verdict_o != RKQ_REPAIR));

  // an abort run stays detected to the end of the window
  p_hit_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !first_i && hit_q) |-> (verdict_o == RKQ_RETAIN));
endmodule

// File: rtl/repair_key_qualifier.sv
module repair_key_qualifier
  import rkq_pkg::*;
#(
  parameter int DQ_W      = 4,
  parameter int CWL_W     = 5,
  parameter int AL_W      = 5,
  parameter int PL_W      = 3,
  parameter int WIN_CLKS  = 4,
  parameter int RUN_CLKS  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_cmd_i,
  input  logic [CWL_W-1:0] cwl_i,
  input  logic [AL_W-1:0]  al_i,
  input  logic [PL_W-1:0]  pl_i,
  input  logic [DQ_W-1:0]  dq_rise_i,
  input  logic [DQ_W-1:0]  dq_fall_i,
  output logic             verdict_valid_o,
  output logic [1:0]       verdict_o,
  output logic             overlap_err_o
);
  localparam int BEATS = 2;
  localparam int RUN_BEATS = RUN_CLKS * BEATS;

  logic cap, first, last, overlap;
  logic [BEATS-1:0][DQ_W-1:0] beats;
  rkq_verdict_e verdict_d;

  logic       valid_q, err_q;
  logic [1:0] code_q;

  assign beats = {dq_fall_i, dq_rise_i};

  rkq_window_ctrl #(
    .CWL_W(CWL_W), .AL_W(AL_W), .PL_W(PL_W), .WIN_CLKS(WIN_CLKS)
  ) u_ctrl (
    .clk_i, .rst_ni, .wr_cmd_i, .cwl_i, .al_i, .pl_i,
    .cap_o(cap), .first_o(first), .last_o(last), .overlap_o(overlap)
  );

  rkq_beat_scan #(
    .DQ_W(DQ_W), .BEATS(BEATS), .RUN_BEATS(RUN_BEATS)
  ) u_scan (
    .clk_i, .rst_ni, .cap_i(cap), .first_i(first), .beats_i(beats),
    .verdict_o(verdict_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      code_q  <= RKQ_IDLE;
      err_q   <= 1'b0;
    end else begin
      valid_q <= last;
      code_q  <= last ? verdict_d : RKQ_IDLE;
      err_q   <= err_q | overlap;
    end
  end

  assign verdict_valid_o = valid_q;
  assign verdict_o       = code_q;
  assign overlap_err_o   = err_q;

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |=> !verdict_valid_o);

  p_code_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !verdict_valid_o |-> (verdict_o == RKQ_IDLE));

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overlap_err_o |=> overlap_err_o);

  p_valid_after_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(verdict_valid_o) |-> $past(cap));
endmodule

// File: tb/repair_key_qualifier_bench.sv
`timescale 1ns/1ps
module repair_key_qualifier_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_cmd = 1'b0;
  logic [4:0] cwl = '0, al = '0;
  logic [2:0] pl = '0;
  logic [3:0] dq_r = '0, dq_f = '0;
  logic       vld, err;
  logic [1:0] code;

  int n_run = 0, n_fail = 0;
  bit err_exp = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  repair_key_qualifier u_repair_key_qualifier (
    .clk_i(clk), .rst_ni(rst_n), .wr_cmd_i(wr_cmd), .cwl_i(cwl), .al_i(al), .pl_i(pl),
    .dq_rise_i(dq_r), .dq_fall_i(dq_f),
    .verdict_valid_o(vld), .verdict_o(code), .overlap_err_o(err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] classify(input logic [7:0][3:0] p);
    int run;
    bit low;
    bit hit;
    low = 1; hit = 0; run = 0;
    for (int i = 0; i < 8; i++) begin
      if (p[i] != 4'h0) low = 0;
      if (p[i] == 4'hF) run++; else run = 0;
      if (run >= 4) hit = 1;
    end
    if (low) return 2'b01;
    if (hit) return 2'b10;
    return 2'b11;
  endfunction

  function automatic logic [7:0][3:0] rand_pat();
    logic [7:0][3:0] p;
    int mode, s, l;
    mode = $urandom_range(0, 5);
    for (int i = 0; i < 8; i++) p[i] = 4'($urandom);
    case (mode)
      0: p = '0;
      1: begin
        l = $urandom_range(4, 8); s = $urandom_range(0, 8 - l);
        for (int i = 0; i < l; i++) p[s+i] = 4'hF;
      end
      2: begin p = '0; p[$urandom_range(0, 7)][$urandom_range(0, 3)] = 1'b1; end
      3: begin
        p = '0; s = $urandom_range(0, 5);
        for (int i = 0; i < 3; i++) p[s+i] = 4'hF;
      end
      5: p = '1;
      default: ;
    endcase
    return p;
  endfunction

  // one command, window, verdict; pairs: beat 2k rising, 2k+1 falling
  task automatic burst(input logic [4:0] c, input logic [4:0] a, input logic [2:0] q,
                       input logic [7:0][3:0] pat, input bit ovl, input bit scramble);
    int wl;
    wl = int'(c) + int'(a) + int'(q);
    if (wl == 0) wl = 1;
    @(negedge clk);
    wr_cmd = 1'b1; cwl = c; al = a; pl = q;
    dq_r = 4'($urandom); dq_f = 4'($urandom);
    for (int j = 1; j <= wl + 3; j++) begin
      @(negedge clk);
      check("R2 no early strobe", int'(vld), 0);
      wr_cmd = (ovl && j == wl + 3) ? 1'b1 : 1'b0;
      if (ovl && j == wl + 3) err_exp = 1'b1;
      if (scramble) begin
        cwl = 5'($urandom); al = 5'($urandom); pl = 3'($urandom);
      end
      if (j >= wl) begin
        dq_r = pat[2*(j-wl)]; dq_f = pat[2*(j-wl)+1];
      end else begin
        dq_r = 4'($urandom); dq_f = 4'($urandom);
      end
    end
    @(negedge clk);
    wr_cmd = 1'b0;
    dq_r = 4'($urandom); dq_f = 4'($urandom);
    check("R2/R8 strobe timing", int'(vld), 1);
    check("R3/R4/R5 verdict code", int'(code), int'(classify(pat)));
    check("R7 overlap flag", int'(err), int'(err_exp));
    @(negedge clk);
    check("R6 strobe width", int'(vld), 0);
    check("R6 idle code", int'(code), 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0][3:0] p;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 valid reset", int'(vld), 0);
    check("R1 code reset", int'(code), 0);
    check("R1 err reset", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    burst(5'd0, 5'd0, 3'd0, '0, 0, 0);                 // R8 zero latency -> 1, R3
    p = '0; for (int i = 1; i < 5; i++) p[i] = 4'hF;   // R4 run crosses clock boundary
    burst(5'd9, 5'd0, 3'd0, p, 0, 0);
    p = '0; for (int i = 4; i < 8; i++) p[i] = 4'hF;   // R4 run at end
    burst(5'd12, 5'd2, 3'd1, p, 0, 0);
    p = '0; for (int i = 5; i < 8; i++) p[i] = 4'hF;   // R5 run of three
    burst(5'd11, 5'd0, 3'd0, p, 0, 0);
    p = '0; p[7][3] = 1'b1;                            // R5 single bit on last beat
    burst(5'd31, 5'd31, 3'd7, p, 0, 0);
    p = '0;                                            // R8 latency scrambled after command
    burst(5'd10, 5'd3, 3'd2, p, 0, 1);
    p = '1;
    burst(5'd1, 5'd0, 3'd0, p, 0, 1);

    for (int k = 0; k < 300; k++)
      burst(5'($urandom_range(0, 20)), 5'($urandom_range(0, 6)), 3'($urandom_range(0, 4)),
            rand_pat(), 0, ($urandom_range(0, 3) == 0));

    burst(5'd8, 5'd0, 3'd0, '0, 1, 0);                 // R7 overlap ignored, flag set
    for (int k = 0; k < 20; k++)                       // R7 flag sticky
      burst(5'($urandom_range(0, 12)), 5'd0, 3'd0, rand_pat(), 0, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule